// File: doc/BRIEF.md
# Page Access-Control and Trap Checker

This block judges every virtual memory access against the access-control code stored in the descriptor of the page being addressed. It receives a 3-bit control code, the kind of access (read, write or read-modify-write), and an abort raised by other checks such as the page-length comparison. From these it decides whether the access must be aborted and whether a memory-management trap should be requested for statistics. It also produces set-strobes for the descriptor's accessed flag and written flag, and for the trap flag in the status register.

A second function selects the address space. When space separation is enabled, a data-stream reference goes to data space. The exception is a specifier built on the program counter (register 7): only autoincrement (mode 2) and autoincrement-deferred (mode 3) on the PC use data space, and every other PC-based mode, plain deferred `(PC)` included, stays in instruction space. All outputs are combinational and are held low unless the access-valid strobe is high.

Top module: `page_acc_check`

## Requirements
- R1: With `accValid` high and control code 0, 3 or 7, `abortReq` is 1 for every access kind and `trapReq` is 0.
- R2: Control code 2 aborts any write-type access (`accKind` 1 write, 2 read-modify-write, 3 treated as read-modify-write) and lets a read (`accKind` 0) through without a trap.
- R3: Control code 1 requests a trap on a read and aborts a write-type access without a trap.
- R4: Control code 4 requests a trap on every access kind, with no abort raised by the code itself.
- R5: Control code 5 requests a trap on write-type accesses only, and never aborts by itself.
- R6: Control code 6 allows every access kind with no abort and no trap.
- R7: `setAcc` is 1 only when the access meets the trap condition of its code and the access is not aborted, whether the abort comes from the code or from `extAbort`.
- R8: `setWr` is 1 exactly when the access is write-type and not aborted.
- R9: `trapReq` and `setTrapFlag` are 1 exactly when the trap condition holds and the access is not aborted. `extAbort` forces `abortReq` to 1.
- R10: `useDspace` is 1 exactly when `dspaceEn` and `dataRef` are both 1 and the specifier is not one that uses register 7 with a mode other than 2 or 3.
- R11: With `accValid` low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accValid | input | 1 | Marks a valid access in this cycle |
| acfCode | input | 3 | Access-control code of the page descriptor |
| accKind | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 same as 2 |
| extAbort | input | 1 | Abort raised by other checks (length, etc.) |
| dataRef | input | 1 | Access belongs to the data stream of an operand |
| dspaceEn | input | 1 | Enables separate data space |
| specMode | input | 3 | Addressing mode of the operand specifier |
| specReg | input | 3 | Register number of the operand specifier |
| abortReq | output | 1 | Abort the access |
| trapReq | output | 1 | Request a management trap |
| setAcc | output | 1 | Set strobe for the descriptor accessed flag |
| setWr | output | 1 | Set strobe for the descriptor written flag |
| setTrapFlag | output | 1 | Set strobe for the status-register trap flag |
| useDspace | output | 1 | Route the access to data space |

## Verification
The bench sweeps every combination of code, access kind, external abort, valid strobe, space enable, data reference, mode and register. It compares every output against a model written from the requirements. This catches a design that raises the accessed flag on every access, one that traps on writes under code 1, and one that sets the trap flag or trap request on an access that is being aborted. It also catches a design that sends plain `(PC)` or its deferred forms to data space, or that forgets to let the length abort suppress the trap.

// File: rtl/page_acc_pkg.sv
package page_acc_pkg;
  localparam int ACF_W  = 3;
  localparam int KIND_W = 2;
  localparam int REG_W  = 3;
  localparam int MODE_W = 3;
  localparam logic [REG_W-1:0] PC_REG = REG_W'(7);

  typedef enum logic [KIND_W-1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_RMW   = 2'd2,
    KIND_RMW2  = 2'd3
  } accKind_e;

  typedef enum logic [ACF_W-1:0] {
    ACF_NONRES = 3'd0,
    ACF_RO_TRP = 3'd1,
    ACF_RO     = 3'd2,
    ACF_RSV3   = 3'd3,
    ACF_RW_TRP = 3'd4,
    ACF_RW_TWR = 3'd5,
    ACF_RW     = 3'd6,
    ACF_RSV7   = 3'd7
  } acfCode_e;

  // strobes from the code decoder to the qualifying datapath
  typedef struct packed {
    logic denyRead;
    logic denyWrite;
    logic trapRead;
    logic trapWrite;
  } acfStrobes_t;
endpackage

// File: rtl/page_acc_ctrl.sv
module page_acc_ctrl
  import page_acc_pkg::*;
(
  input  logic [ACF_W-1:0] acfCode,
  output acfStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    unique case (acfCode)
      ACF_RO_TRP: begin
        strobes.denyWrite = 1'b1;
        strobes.trapRead  = 1'b1;
      end
      ACF_RO: strobes.denyWrite = 1'b1;
      ACF_RW_TRP: begin
        strobes.trapRead  = 1'b1;
        strobes.trapWrite = 1'b1;
      end
      ACF_RW_TWR: strobes.trapWrite = 1'b1;
      ACF_RW: strobes = '0;
      default: begin
        strobes.denyRead  = 1'b1;
        strobes.denyWrite = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/page_acc_dpath.sv
module page_acc_dpath
  import page_acc_pkg::*;
(
  input  logic              accValid,
  input  logic [KIND_W-1:0] accKind,
  input  logic              extAbort,
  input  acfStrobes_t       strobes,
  output logic              abortReq,
  output logic              trapHit,
  output logic              setAcc,
  output logic              setWr
);
  logic isWrite;
  logic codeAbort;
  logic trapCond;

  always_comb begin
    isWrite   = (accKind != KIND_READ);
    codeAbort = isWrite ? strobes.denyWrite : strobes.denyRead;
    trapCond  = isWrite ? strobes.trapWrite : strobes.trapRead;
    abortReq  = accValid & (codeAbort | extAbort);
    trapHit   = accValid & trapCond & ~abortReq;
    setAcc    = trapHit;
    setWr     = accValid & isWrite & ~abortReq;
  end
endmodule

// File: rtl/page_space_sel.sv
module page_space_sel
  import page_acc_pkg::*;
(
  input  logic              accValid,
  input  logic              dataRef,
  input  logic              dspaceEn,
  input  logic [MODE_W-1:0] specMode,
  input  logic [REG_W-1:0]  specReg,
  output logic              useDspace
);
  logic pcStream;

  always_comb begin
    // PC-based specifiers stay in I space except autoinc and autoinc-deferred
    pcStream  = (specReg == PC_REG) &&
                (specMode != MODE_W'(2)) && (specMode != MODE_W'(3));
    useDspace = accValid & dspaceEn & dataRef & ~pcStream;
  end
endmodule

// File: rtl/page_acc_check.sv
module page_acc_check
  import page_acc_pkg::*;
(
  input  logic       accValid,
  input  logic [2:0] acfCode,
  input  logic [1:0] accKind,
  input  logic       extAbort,
  input  logic       dataRef,
  input  logic       dspaceEn,
  input  logic [2:0] specMode,
  input  logic [2:0] specReg,
  output logic       abortReq,
  output logic       trapReq,
  output logic       setAcc,
  output logic       setWr,
  output logic       setTrapFlag,
  output logic       useDspace
);
  acfStrobes_t strobes;
  logic        trapHit;

  page_acc_ctrl uCtrl (
    .acfCode (acfCode),
    .strobes (strobes)
  );

  page_acc_dpath uDpath (
    .accValid (accValid),
    .accKind  (accKind),
    .extAbort (extAbort),
    .strobes  (strobes),
    .abortReq (abortReq),
    .trapHit  (trapHit),
    .setAcc   (setAcc),
    .setWr    (setWr)
  );

  page_space_sel uSpace (
    .accValid  (accValid),
    .dataRef   (dataRef),
    .dspaceEn  (dspaceEn),
    .specMode  (specMode),
    .specReg   (specReg),
    .useDspace (useDspace)
  );

  assign trapReq     = trapHit;
  assign setTrapFlag = trapHit;
endmodule

// File: rtl/page_acc_check_sva.sv
module page_acc_check_sva (
  input logic       accValid,
  input logic [2:0] acfCode,
  input logic [1:0] accKind,
  input logic       extAbort,
  input logic       dspaceEn,
  input logic       dataRef,
  input logic       abortReq,
  input logic       trapReq,
  input logic       setAcc,
  input logic       setWr,
  input logic       setTrapFlag,
  input logic       useDspace
);
  always_comb begin
    // R1
    nonres_abort_chk: assert (!(accValid && (acfCode == 3'd0 || acfCode == 3'd3 ||
                                 acfCode == 3'd7)) || (abortReq && !trapReq))
      else $error("reserved or non-resident code not aborted");
    // R3
    ro_trap_write_chk: assert (!(accValid && acfCode == 3'd1 && accKind != 2'd0) ||
                                (abortReq && !trapReq))
      else $error("code 1 write not aborted cleanly");
    // R6
    rw_free_chk: assert (!(accValid && acfCode == 3'd6 && !extAbort) ||
                          (!abortReq && !trapReq))
      else $error("code 6 access blocked or trapped");
    // R7
    acc_flag_chk: assert (!setAcc || (accValid && !abortReq && trapReq))
      else $error("accessed flag on aborted or non-trapping access");
    // R8
    wr_flag_chk: assert (!setWr || (accKind != 2'd0 && !abortReq))
      else $error("written flag on read or aborted access");
    // R9
    trap_abort_chk: assert (!(trapReq || setTrapFlag) || !abortReq)
      else $error("trap raised with abort");
    // R9
    ext_abort_chk: assert (!(accValid && extAbort) || abortReq)
      else $error("external abort dropped");
    // R10
    dspace_en_chk: assert (!useDspace || (dspaceEn && dataRef))
      else $error("data space without enable");
    // R11
    idle_quiet_chk: assert (accValid || !(abortReq || trapReq || setAcc || setWr ||
                                          setTrapFlag || useDspace))
      else $error("output active without valid");
  end
endmodule

bind page_acc_check page_acc_check_sva uSva (
  .accValid    (accValid),
  .acfCode     (acfCode),
  .accKind     (accKind),
  .extAbort    (extAbort),
  .dspaceEn    (dspaceEn),
  .dataRef     (dataRef),
  .abortReq    (abortReq),
  .trapReq     (trapReq),
  .setAcc      (setAcc),
  .setWr       (setWr),
  .setTrapFlag (setTrapFlag),
  .useDspace   (useDspace)
);

// File: tb/page_acc_check_test.sv
module page_acc_check_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       accValid = 1'b0;
  logic [2:0] acfCode  = 3'd0;
  logic [1:0] accKind  = 2'd0;
  logic       extAbort = 1'b0;
  logic       dataRef  = 1'b0;
  logic       dspaceEn = 1'b0;
  logic [2:0] specMode = 3'd0;
  logic [2:0] specReg  = 3'd0;
  logic abortReq, trapReq, setAcc, setWr, setTrapFlag, useDspace;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_acc_check uut (
    .accValid (accValid), .acfCode (acfCode), .accKind (accKind),
    .extAbort (extAbort), .dataRef (dataRef), .dspaceEn (dspaceEn),
    .specMode (specMode), .specReg (specReg),
    .abortReq (abortReq), .trapReq (trapReq), .setAcc (setAcc),
    .setWr (setWr), .setTrapFlag (setTrapFlag), .useDspace (useDspace)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s code=%0d kind=%0d ext=%0d v=%0d act=%0b exp=%0b",
               req, what, acfCode, accKind, extAbort, accValid, act, exp);
    end
  endtask

  // requirement tag for the per-code abort/trap rule
  function automatic string codeReq(input int c);
    case (c)
      0, 3, 7: return "R1";
      2: return "R2";
      1: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset/idle state: R11
    check("R11", "abort idle", abortReq, 1'b0);
    check("R11", "dspace idle", useDspace, 1'b0);
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int e = 0; e < 2; e++) begin
          for (int v = 0; v < 2; v++) begin
            for (int s = 0; s < 16; s++) begin
              for (int m = 0; m < 8; m++) begin
                for (int r = 0; r < 8; r += 7) begin
                  bit wr, cAb, cTr, ab, tr, ds;
                  acfCode  = 3'(c);
                  accKind  = 2'(k);
                  extAbort = e[0];
                  accValid = v[0];
                  dspaceEn = s[0];
                  dataRef  = s[1];
                  specMode = 3'(m);
                  specReg  = 3'(r == 0 ? s[3:2] : 7);
                  wr  = (k != 0);
                  cAb = (c == 0 || c == 3 || c == 7) || ((c == 1 || c == 2) && wr);
                  cTr = (c == 4) || (c == 1 && !wr) || (c == 5 && wr);
                  ab  = v[0] && (cAb || e[0]);
                  tr  = v[0] && cTr && !ab;
                  ds  = v[0] && s[0] && s[1] &&
                        !(specReg == 3'd7 && m != 2 && m != 3);
                  @(posedge clk);
                  @(negedge clk);
                  if (!v[0]) begin
                    check("R11", "quiet", abortReq | trapReq | setAcc | setWr |
                          setTrapFlag | useDspace, 1'b0);
                  end else begin
                    if (e == 0) begin
                      check(codeReq(c), "abort", abortReq, ab);
                      check(codeReq(c), "trap", trapReq, tr);
                    end else begin
                      check("R9", "ext abort", abortReq, 1'b1);
                      check("R9", "trap under abort", trapReq, tr);
                    end
                    check("R7", "acc flag", setAcc, tr);
                    check("R8", "wr flag", setWr, v[0] && wr && !ab);
                    check("R9", "trap flag", setTrapFlag, tr);
                    check("R10", "dspace", useDspace, ds);
                  end
                end
              end
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule